// File: doc/BRIEF.md
# Staggered Channel Output Controller

This block sits between a 24-bit latched display word and the 24 channel drivers of a three-colour LED driver. It holds the most recent word it accepted and steers each group of eight serial bits onto the red, green or blue channels according to a 3-bit colour-order code. Each colour has its own active-low enable. When an enable falls, that colour's channels switch on one after another in fixed steps of the fast clock, so the load current rises gradually. A configuration bit turns the stagger off, and then all channels of the colour switch together. A thermal shutdown input blanks every channel while it is high.

With automatic power-off selected, accepting an all-zero word puts the block to sleep and raises `pwr_down`. The next accepted word that has a 1 in it wakes the block. Configuration writes that arrive during sleep are dropped. The delay elements are modelled as a counter on the fast clock, and `STEP_CYC` sets how many cycles one stagger step takes. All inputs are assumed synchronous to `clk`.

The word input is a valid/ready stream with no back-pressure: `lat_ready` is always high, so a word is taken on every edge where `lat_valid` is high. Configuration, enables and thermal inputs are plain level signals.

Top module: `stagger_out_ctrl`

## Requirements
- R1: Once reset is released, `ch_on` is all zeros and `pwr_down` is 0. The configuration resets to order code 000, stagger on and automatic power-off off.
- R2: `ch_on` bit c*CPC+(n-1) drives channel n of colour c (R=0, G=1, B=2). Under order 000, `lat_data[23]` (the first serial bit) maps to R8, bit 16 to R1, bits 15..8 to G8..G1 and bits 7..0 to B8..B1.
- R3: Under order code k, `lat_data[23:16]`, `[15:8]` and `[7:0]` carry, in that order, the colours: 000 R,G,B; 001 G,B,R; 010 G,R,B; 011 B,G,R; 100 B,R,G; 101 R,B,G. Within each byte the higher bit is the higher channel number.
- R4: Order codes 110 and 111 map exactly like 000.
- R5: With the stagger on, suppose a colour's enable is first sampled low at edge k and stays low. Channel n of that colour is on from edge k+(n-1)*STEP_CYC onward, provided its latched bit is 1.
- R6: With the stagger off (`cfg_grad_off`=1), every channel of a colour follows its latched bit from the first edge at which that colour's enable is sampled low.
- R7: A colour's channels are off after every edge at which its enable is sampled high. A later fall of the enable restarts that colour's stagger.
- R8: After every edge at which `therm_sd` is sampled high, all of `ch_on` is 0. Once it clears, the outputs return to their normal values.
- R9: With automatic power-off enabled, accepting an all-zero word sets `pwr_down` after that edge. With it disabled, a zero word leaves `pwr_down` at 0.
- R10: An accepted word that has at least one 1 clears `pwr_down` after that edge.
- R11: A `cfg_wr` pulse while `pwr_down` is 1 changes no setting. The order, stagger and power-off settings in force before sleep still apply after wake-up.
- R12: `lat_ready` is always 1. The accepted word is held while `lat_valid` is low, whatever `lat_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one tick is the stagger time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_valid | input | 1 | Latched word offered |
| lat_ready | output | 1 | Word accepted (always 1) |
| lat_data | input | 3*CPC | Latched word, bit 23 is the first serial bit |
| cfg_wr | input | 1 | Load the three configuration fields below |
| cfg_order | input | 3 | Colour-order code |
| cfg_grad_off | input | 1 | 1 = no stagger |
| cfg_apo_en | input | 1 | 1 = automatic power-off on zero words |
| en_n | input | 3 | Active-low colour enables, bit 0 red, 1 green, 2 blue |
| therm_sd | input | 1 | Thermal shutdown, forces all channels off |
| ch_on | output | 3*CPC | Channel on lines, colour-major, channel 1 lowest |
| pwr_down | output | 1 | Sleep state request |

## Verification
The bench builds the block with eight channels per colour and `STEP_CYC` set to 3. With that setting each channel's turn-on edge lies three cycles from its neighbour's, so an off-by-one in a threshold or a wrong step shows up at a single channel. The longest run to R8, B8 and G8 is 21 cycles, which keeps every stagger sweep short enough to repeat under all eight order codes. Each order-code sweep latches a word whose three bytes differ, so any swap of colour groups changes the outputs.

// File: rtl/stg_pkg.sv
package stg_pkg;

  // Colour indices used across the block
  localparam int COL_R = 0;
  localparam int COL_G = 1;
  localparam int COL_B = 2;
  localparam int NCOLOR = 3;

  typedef enum logic [2:0] {
    ORD_RGB = 3'd0,
    ORD_GBR = 3'd1,
    ORD_GRB = 3'd2,
    ORD_BGR = 3'd3,
    ORD_BRG = 3'd4,
    ORD_RBG = 3'd5
  } ord_e;

  typedef struct packed {
    logic [2:0] order;
    logic       grad_off;
    logic       apo_en;
  } cfg_t;

  // Serial slot (0 = first byte shifted in) that carries a given colour
  function automatic logic [1:0] color_slot(input logic [2:0] ord, input int color);
    logic [1:0] sr, sg, sb;
    case (ord_e'(ord))
      ORD_GBR: begin sr = 2'd2; sg = 2'd0; sb = 2'd1; end
      ORD_GRB: begin sr = 2'd1; sg = 2'd0; sb = 2'd2; end
      ORD_BGR: begin sr = 2'd2; sg = 2'd1; sb = 2'd0; end
      ORD_BRG: begin sr = 2'd1; sg = 2'd2; sb = 2'd0; end
      ORD_RBG: begin sr = 2'd0; sg = 2'd2; sb = 2'd1; end
      default: begin sr = 2'd0; sg = 2'd1; sb = 2'd2; end
    endcase
    case (color)
      COL_R:   return sr;
      COL_G:   return sg;
      default: return sb;
    endcase
  endfunction

endpackage

// File: rtl/stg_order_map.sv
module stg_order_map
  import stg_pkg::*;
#(
  parameter int CPC = 8
) (
  input  logic [2:0]            order,
  input  logic [NCOLOR*CPC-1:0] raw,
  output logic [NCOLOR*CPC-1:0] mapped
);

  for (genvar c = 0; c < NCOLOR; c++) begin : g_col
    logic [1:0] slot;
    assign slot = color_slot(order, c);
    always_comb begin
      case (slot)
        2'd0:    mapped[c*CPC +: CPC] = raw[2*CPC +: CPC];
        2'd1:    mapped[c*CPC +: CPC] = raw[CPC +: CPC];
        default: mapped[c*CPC +: CPC] = raw[0 +: CPC];
      endcase
    end
  end

endmodule

// File: rtl/stg_stagger.sv
module stg_stagger #(
  parameter int CPC      = 8,
  parameter int STEP_CYC = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_n,
  input  logic           grad_off,
  output logic [CPC-1:0] gate
);

  localparam int RUN_MAX = (CPC - 1) * STEP_CYC + 1;
  localparam int RW      = $clog2(RUN_MAX + 1);

  // Edges since the enable was first sampled low, saturating
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run <= '0;
    else if (en_n)                 run <= '0;
    else if (run != RW'(RUN_MAX))  run <= run + 1'b1;
  end

  for (genvar k = 0; k < CPC; k++) begin : g_thr
    localparam int THR = k * STEP_CYC;
    assign gate[k] = grad_off ? (run != '0) : (run > RW'(THR));
  end

endmodule

// File: rtl/stg_sleep.sv
module stg_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_fire,
  input  logic lat_zero,
  input  logic apo_en,
  output logic asleep
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0;
    end else if (lat_fire) begin
      if (!lat_zero)   asleep <= 1'b0;
      else if (apo_en) asleep <= 1'b1;
    end
  end

endmodule

// File: rtl/stagger_out_ctrl.sv
module stagger_out_ctrl
  import stg_pkg::*;
#(
  parameter int CPC      = 8,
  parameter int STEP_CYC = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lat_valid,
  output logic                  lat_ready,
  input  logic [3*CPC-1:0]      lat_data,
  input  logic                  cfg_wr,
  input  logic [2:0]            cfg_order,
  input  logic                  cfg_grad_off,
  input  logic                  cfg_apo_en,
  input  logic [2:0]            en_n,
  input  logic                  therm_sd,
  output logic [3*CPC-1:0]      ch_on,
  output logic                  pwr_down
);

  localparam int NCH = NCOLOR * CPC;

  cfg_t            cfg_q;
  logic [NCH-1:0]  word_q;
  logic            therm_q;
  logic            asleep;
  logic [NCH-1:0]  mapped;
  logic [NCH-1:0]  gates;
  logic            lat_fire;

  assign lat_ready = 1'b1;
  assign lat_fire  = lat_valid & lat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      word_q  <= '0;
      therm_q <= 1'b0;
    end else begin
      if (cfg_wr && !asleep) begin
        cfg_q.order    <= cfg_order;
        cfg_q.grad_off <= cfg_grad_off;
        cfg_q.apo_en   <= cfg_apo_en;
      end
      if (lat_fire) word_q <= lat_data;
      therm_q <= therm_sd;
    end
  end

  stg_order_map #(.CPC(CPC)) map_i (
    .order  (cfg_q.order),
    .raw    (word_q),
    .mapped (mapped)
  );

  for (genvar c = 0; c < NCOLOR; c++) begin : g_stg
    stg_stagger #(.CPC(CPC), .STEP_CYC(STEP_CYC)) stg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_n     (en_n[c]),
      .grad_off (cfg_q.grad_off),
      .gate     (gates[c*CPC +: CPC])
    );
  end

  stg_sleep sleep_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_fire (lat_fire),
    .lat_zero (lat_data == '0),
    .apo_en   (cfg_q.apo_en),
    .asleep   (asleep)
  );

  assign ch_on    = therm_q ? '0 : (mapped & gates);
  assign pwr_down = asleep;

endmodule

// File: rtl/stg_ctrl_chk.sv
module stg_ctrl_chk #(
  parameter int CPC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lat_valid,
  input logic [3*CPC-1:0]   lat_data,
  input logic [2:0]         en_n,
  input logic               therm_sd,
  input logic [3*CPC-1:0]   ch_on,
  input logic               pwr_down
);

  // R8
  therm_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_sd |=> (ch_on == '0));

  // R7
  red_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n[0] |=> (ch_on[0 +: CPC] == '0));

  // R7
  green_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n[1] |=> (ch_on[CPC +: CPC] == '0));

  // R7
  blue_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n[2] |=> (ch_on[2*CPC +: CPC] == '0));

  // R9
  sleep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> ($past(lat_valid) && ($past(lat_data) == '0)));

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && lat_valid && (lat_data != '0)) |=> !pwr_down);

endmodule

bind stagger_out_ctrl stg_ctrl_chk #(.CPC(CPC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lat_valid (lat_valid),
  .lat_data  (lat_data),
  .en_n      (en_n),
  .therm_sd  (therm_sd),
  .ch_on     (ch_on),
  .pwr_down  (pwr_down)
);

// File: tb/stagger_out_ctrl_tb_top.sv
module stagger_out_ctrl_tb_top;

  localparam int CPC  = 8;
  localparam int STEP = 3;
  localparam int W    = 3 * CPC;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lat_valid = 1'b0;
  logic         lat_ready;
  logic [W-1:0] lat_data = '0;
  logic         cfg_wr = 1'b0;
  logic [2:0]   cfg_order = '0;
  logic         cfg_grad_off = 1'b0;
  logic         cfg_apo_en = 1'b0;
  logic [2:0]   en_n = 3'b111;
  logic         therm_sd = 1'b0;
  logic [W-1:0] ch_on;
  logic         pwr_down;

  always #2 clk = ~clk;

  stagger_out_ctrl #(.CPC(CPC), .STEP_CYC(STEP)) dut_i (
    .clk, .rst_n, .lat_valid, .lat_ready, .lat_data, .cfg_wr, .cfg_order,
    .cfg_grad_off, .cfg_apo_en, .en_n, .therm_sd, .ch_on, .pwr_down
  );

  // Reference model state
  int           run [3];
  logic [W-1:0] m_lat;
  logic [2:0]   m_ord;
  logic         m_grad_off, m_apo, m_sleep, m_therm;

  int    nchk = 0, nerr = 0, wd = 0;
  bit    started = 0, done = 0;
  string phase = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) run[c] = 0;
      m_lat = '0; m_ord = '0; m_grad_off = 0; m_apo = 0; m_sleep = 0; m_therm = 0;
    end else begin
      logic nxt_sleep;
      nxt_sleep = m_sleep;
      for (int c = 0; c < 3; c++) begin
        if (en_n[c]) run[c] = 0;
        else if (run[c] < (CPC - 1) * STEP + 1) run[c] = run[c] + 1;
      end
      if (lat_valid) begin
        if (lat_data != 0) nxt_sleep = 0;
        else if (m_apo) nxt_sleep = 1;
        m_lat = lat_data;
      end
      if (cfg_wr && !m_sleep) begin
        m_ord = cfg_order; m_grad_off = cfg_grad_off; m_apo = cfg_apo_en;
      end
      m_sleep = nxt_sleep;
      m_therm = therm_sd;
    end
  end

  // Colour sequence in serial order for each code; returns slot of colour c
  function automatic int slot_of(logic [2:0] ord, int c);
    int seq [3];
    case (ord)
      3'd1: seq = '{1, 2, 0};
      3'd2: seq = '{1, 0, 2};
      3'd3: seq = '{2, 1, 0};
      3'd4: seq = '{2, 0, 1};
      3'd5: seq = '{0, 2, 1};
      default: seq = '{0, 1, 2};
    endcase
    for (int i = 0; i < 3; i++) if (seq[i] == c) return i;
    return 0;
  endfunction

  function automatic logic [W-1:0] exp_on();
    logic [W-1:0] e;
    e = '0;
    for (int c = 0; c < 3; c++) begin
      for (int n = 0; n < CPC; n++) begin
        int s, thr;
        s   = slot_of(m_ord, c);
        thr = m_grad_off ? 0 : n * STEP;
        e[c*CPC + n] = m_lat[(2 - s)*CPC + n] && (run[c] > thr) && !m_therm;
      end
    end
    return e;
  endfunction

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("ch_on", ch_on, exp_on());
      chk("pwr_down", W'(pwr_down), W'(m_sleep));
      chk("lat_ready R12", W'(lat_ready), W'(1'b1));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(logic [W-1:0] d);
    lat_valid = 1'b1; lat_data = d;
    @(negedge clk);
    lat_valid = 1'b0;
  endtask

  task automatic cfg(logic [2:0] o, logic g, logic a);
    cfg_wr = 1'b1; cfg_order = o; cfg_grad_off = g; cfg_apo_en = a;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    started = 1;
    rst_n = 1'b1;
    cyc(3);

    phase = "R2";
    en_n = 3'b000;
    latch(24'h800000); cyc(30);
    latch(24'h000001); cyc(5);
    latch(24'h010000); cyc(5);
    latch(24'h00FF00); cyc(5);

    phase = "R5";
    en_n = 3'b111; latch(24'hFFFFFF); cyc(3);
    en_n = 3'b000; cyc(28);

    phase = "R7";
    en_n = 3'b001; cyc(4);
    en_n = 3'b100; cyc(4);
    en_n = 3'b010; cyc(4);
    en_n = 3'b000; cyc(25);

    phase = "R3";
    for (int o = 0; o < 6; o++) begin
      cfg(3'(o), 1'b0, 1'b0);
      en_n = 3'b111; latch(24'hC35A81);
      en_n = 3'b000; cyc(25);
    end

    phase = "R4";
    for (int o = 6; o < 8; o++) begin
      cfg(3'(o), 1'b0, 1'b0);
      en_n = 3'b111; latch(24'h3CA518);
      en_n = 3'b000; cyc(25);
    end

    phase = "R6";
    cfg(3'd0, 1'b1, 1'b0);
    en_n = 3'b111; cyc(2);
    en_n = 3'b000; cyc(6);
    latch(24'h5A5A5A); cyc(4);

    phase = "R8";
    therm_sd = 1'b1; cyc(4);
    therm_sd = 1'b0; cyc(4);

    phase = "R9";
    cfg(3'd0, 1'b0, 1'b0);
    latch(24'h000000); cyc(4);
    cfg(3'd0, 1'b0, 1'b1);
    latch(24'h000000); cyc(4);

    phase = "R11";
    cfg(3'd3, 1'b1, 1'b0); cyc(2);

    phase = "R10";
    en_n = 3'b111; latch(24'h800001);
    en_n = 3'b000; cyc(25);

    phase = "R12";
    latch(24'h123456);
    lat_data = 24'hFFFFFF; cyc(3);
    lat_data = 24'h000000; cyc(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule